// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the control register file of a CPU-to-PCI host bridge. It sits in a 4 KB memory-mapped window on a simple synchronous bus and decodes word registers from bits [11:2] of the bus address. Each writable register keeps only its own bit mask. A write to the low bound of an address window also loads that window's remap register. Error, ECC, sync-barrier and multi-device registers are read-only. They return fixed values, and a sync-barrier read returns a marker word.

A byte-order strap chooses between little-endian and big-endian operation. It selects the reset values of the CPU configuration and PCI command registers. In big-endian mode it also reverses the bytes of every write and every read. The block holds the PCI configuration-address latch itself. It does not run configuration-data cycles: it passes them out on a request port with strobes and data, and it returns the reply word as read data.

Top module: `hbr_regfile`

## Requirements
- R1: The register is chosen by bus_addr[11:2] only; bus_addr[1:0] do not affect which register is written or read.
- R2: A write to a window low-bound register (word indices 0x012, 0x016, 0x020, 0x024, 0x028, 0x02C for windows 0 to 5) stores bits [14:0]. The same write loads that window's remap register (index 0x03C + 2*window) with bits [10:0].
- R3: A window high-bound register (low-bound index + 2) stores bits [6:0]. A direct write to a remap register stores bits [10:0] and leaves the low bound unchanged.
- R4: The two PCI command registers (indices 0x300, 0x320) store the written value AND 0x0401FC0F. The configuration-address latch (index 0x33E) stores the value AND 0x80FFFFFC and drives it on cfg_addr_o.
- R5: Writes to the CPU error registers (0x01C, 0x01E, 0x04A, 0x04C, 0x04E), the ECC registers (0x120 to 0x124), the sync-barrier registers (0x030, 0x032) and the multi-device register (0x048) have no effect. The multi-device register always reads 0.
- R6: A read of either sync-barrier register returns 0xC000FFEE, byte-reversed in big-endian mode.
- R7: After reset the CPU error data registers (0x04A, 0x04C) read 0xFFFFFFFF and the parity register (0x04E) reads 0x000000FF. The SDRAM bank parameter registers (0x113 to 0x116) read 5 and store any written value unchanged. The window bounds and remaps reset to low/high/remap of 0x080/0x00F/0x080, 0x090/0x01F/0x090, 0x790/0x01F/0x790, 0x100/0x00F/0x100, 0x110/0x01F/0x110 and 0x120/0x02F/0x120 for windows 0 to 5.
- R8: With big_endian_i low during reset, the CPU configuration register (0x000) resets to 0x00001000 and both PCI command registers reset to 0x00010001. With big_endian_i high, all three reset to 0.
- R9: With big_endian_i high, write data is byte-reversed before the mask is applied and before it is stored, and read data is byte-reversed before it is returned.
- R10: Every word index not named above ignores writes and reads 0.
- R11: bus_rdata is registered. It carries the addressed value from the clock edge that samples bus_re, and it holds its value when bus_re is low.
- R12: A write to index 0x33F raises cfg_wr_o in the same cycle, with cfg_wdata_o equal to the byte-order-corrected data. A read of 0x33F raises cfg_rd_o, and the cfg_rdata_i value sampled at that edge, byte-order-corrected, becomes bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian_i | input | 1 | Byte-order strap, 1 = big-endian |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cfg_addr_o | output | 32 | Configuration-address latch contents |
| cfg_wr_o | output | 1 | Configuration-data write request |
| cfg_rd_o | output | 1 | Configuration-data read request |
| cfg_wdata_o | output | 32 | Configuration-data write value, native byte order |
| cfg_rdata_i | input | 32 | Configuration-data reply, native byte order |

## Verification
The assertions assume that big_endian_i changes only while rst_n is low and that bus_we and bus_re are never high in the same cycle. A mid-run strap change would make the byte-order checks compare values across two different modes. The stimulus drives a single strobe per cycle, from one access task at a time, and it changes the strap only inside a reset pulse. cfg_rdata_i is held steady across each read so that the sampled reply is well defined.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  localparam int unsigned DW      = 32;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_WIN = 6;

  localparam logic [IDX_W-1:0] IX_CPU     = 10'h000;
  localparam logic [IDX_W-1:0] IX_ERR_AL  = 10'h01C;
  localparam logic [IDX_W-1:0] IX_ERR_AH  = 10'h01E;
  localparam logic [IDX_W-1:0] IX_SYNC0   = 10'h030;
  localparam logic [IDX_W-1:0] IX_SYNC1   = 10'h032;
  localparam logic [IDX_W-1:0] IX_MULTI   = 10'h048;
  localparam logic [IDX_W-1:0] IX_ERR_DL  = 10'h04A;
  localparam logic [IDX_W-1:0] IX_ERR_DH  = 10'h04C;
  localparam logic [IDX_W-1:0] IX_ERR_PAR = 10'h04E;
  localparam logic [IDX_W-1:0] IX_BANK0   = 10'h113;
  localparam logic [IDX_W-1:0] IX_ECC_LO  = 10'h120;
  localparam logic [IDX_W-1:0] IX_ECC_HI  = 10'h124;
  localparam logic [IDX_W-1:0] IX_CMD0    = 10'h300;
  localparam logic [IDX_W-1:0] IX_CMD1    = 10'h320;
  localparam logic [IDX_W-1:0] IX_CFGA    = 10'h33E;
  localparam logic [IDX_W-1:0] IX_CFGD    = 10'h33F;
  localparam logic [IDX_W-1:0] IX_REMAP0  = 10'h03C;

  localparam logic [DW-1:0] MSK_LOW    = 32'h0000_7FFF;
  localparam logic [DW-1:0] MSK_HIGH   = 32'h0000_007F;
  localparam logic [DW-1:0] MSK_REMAP  = 32'h0000_07FF;
  localparam logic [DW-1:0] MSK_CMD    = 32'h0401_FC0F;
  localparam logic [DW-1:0] MSK_CFGA   = 32'h80FF_FFFC;
  localparam logic [DW-1:0] SYNC_MARK  = 32'hC000_FFEE;
  localparam logic [DW-1:0] RST_CPU_LE = 32'h0000_1000;
  localparam logic [DW-1:0] RST_CMD_LE = 32'h0001_0001;
  localparam logic [DW-1:0] RST_BANK   = 32'h0000_0005;

  typedef enum logic [3:0] {
    K_NONE, K_CPU, K_WLOW, K_WHIGH, K_WREMAP, K_CMD,
    K_CFGA, K_CFGD, K_BANK, K_SYNC, K_CONST
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [SEL_W-1:0] sel;
    logic [DW-1:0]    konst;
  } dec_t;

  function automatic logic [IDX_W-1:0] win_low_idx(input int w);
    case (w)
      0:       return 10'h012;
      1:       return 10'h016;
      2:       return 10'h020;
      3:       return 10'h024;
      4:       return 10'h028;
      default: return 10'h02C;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] win_high_idx(input int w);
    return win_low_idx(w) + 10'd2;
  endfunction

  function automatic logic [IDX_W-1:0] win_remap_idx(input int w);
    return IX_REMAP0 + IDX_W'(2 * w);
  endfunction

  function automatic logic [DW-1:0] win_low_rst(input int w);
    case (w)
      0:       return 32'h080;
      1:       return 32'h090;
      2:       return 32'h790;
      3:       return 32'h100;
      4:       return 32'h110;
      default: return 32'h120;
    endcase
  endfunction

  function automatic logic [DW-1:0] win_high_rst(input int w);
    case (w)
      0, 3:    return 32'h00F;
      5:       return 32'h02F;
      default: return 32'h01F;
    endcase
  endfunction

  function automatic logic [DW-1:0] bswap32(input logic [DW-1:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

endpackage

// File: rtl/hbr_byteswap.sv
module hbr_byteswap #(
  parameter int unsigned W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned NBYTES = W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[8*b +: 8] = en ? din[8*(NBYTES-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 6,
  parameter int unsigned NUM_BANK = 4
) (
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);
  always_comb begin
    dec       = '0;
    dec.kind  = K_NONE;
    if (idx == IX_CPU) dec.kind = K_CPU;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (idx == win_low_idx(w))   begin dec.kind = K_WLOW;   dec.sel = SEL_W'(w); end
      if (idx == win_high_idx(w))  begin dec.kind = K_WHIGH;  dec.sel = SEL_W'(w); end
      if (idx == win_remap_idx(w)) begin dec.kind = K_WREMAP; dec.sel = SEL_W'(w); end
    end
    for (int b = 0; b < int'(NUM_BANK); b++) begin
      if (idx == IX_BANK0 + IDX_W'(b)) begin dec.kind = K_BANK; dec.sel = SEL_W'(b); end
    end
    if (idx == IX_CMD0) begin dec.kind = K_CMD; dec.sel = 3'd0; end
    if (idx == IX_CMD1) begin dec.kind = K_CMD; dec.sel = 3'd1; end
    if (idx == IX_CFGA) dec.kind = K_CFGA;
    if (idx == IX_CFGD) dec.kind = K_CFGD;
    if (idx == IX_SYNC0 || idx == IX_SYNC1) dec.kind = K_SYNC;
    if (idx == IX_MULTI || idx == IX_ERR_AL || idx == IX_ERR_AH ||
        (idx >= IX_ECC_LO && idx <= IX_ECC_HI)) begin
      dec.kind  = K_CONST;
      dec.konst = '0;
    end
    if (idx == IX_ERR_DL || idx == IX_ERR_DH) begin
      dec.kind  = K_CONST;
      dec.konst = 32'hFFFF_FFFF;
    end
    if (idx == IX_ERR_PAR) begin
      dec.kind  = K_CONST;
      dec.konst = 32'h0000_00FF;
    end
  end
endmodule

// File: rtl/hbr_window_bank.sv
module hbr_window_bank
  import hbr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  kind_e                        kind,
  input  logic [SEL_W-1:0]             sel,
  input  logic [DW-1:0]                wd,
  output logic [NUM_WIN-1:0][DW-1:0]   low_q,
  output logic [NUM_WIN-1:0][DW-1:0]   high_q,
  output logic [NUM_WIN-1:0][DW-1:0]   remap_q
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit;
    assign hit = wr_en && (sel == SEL_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        low_q[w]   <= win_low_rst(w);
        high_q[w]  <= win_high_rst(w);
        remap_q[w] <= win_low_rst(w);
      end else if (hit) begin
        case (kind)
          K_WLOW: begin
            low_q[w]   <= wd & MSK_LOW;
            remap_q[w] <= wd & MSK_REMAP;
          end
          K_WHIGH:  high_q[w]  <= wd & MSK_HIGH;
          K_WREMAP: remap_q[w] <= wd & MSK_REMAP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
  import hbr_pkg::*;
#(
  parameter int unsigned NUM_BANK = 4,
  parameter int unsigned NUM_CMD  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        be_strap,
  input  logic                        wr_en,
  input  kind_e                       kind,
  input  logic [SEL_W-1:0]            sel,
  input  logic [DW-1:0]               wd,
  output logic [DW-1:0]               cpu_q,
  output logic [NUM_CMD-1:0][DW-1:0]  cmd_q,
  output logic [DW-1:0]               cfga_q,
  output logic [NUM_BANK-1:0][DW-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_q  <= be_strap ? '0 : RST_CPU_LE;
      cfga_q <= '0;
    end else if (wr_en) begin
      if (kind == K_CPU)  cpu_q  <= wd;
      if (kind == K_CFGA) cfga_q <= wd & MSK_CFGA;
    end
  end

  for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmd_q[c] <= be_strap ? '0 : RST_CMD_LE;
      else if (wr_en && kind == K_CMD && sel == SEL_W'(c))
        cmd_q[c] <= wd & MSK_CMD;
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[b] <= RST_BANK;
      else if (wr_en && kind == K_BANK && sel == SEL_W'(b))
        bank_q[b] <= wd;
    end
  end
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
  import hbr_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 6,
  parameter int unsigned NUM_BANK = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian_i,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  output logic [31:0] cfg_addr_o,
  output logic        cfg_wr_o,
  output logic        cfg_rd_o,
  output logic [31:0] cfg_wdata_o,
  input  logic [31:0] cfg_rdata_i
);
  localparam int unsigned NUM_CMD = 2;
  localparam int unsigned BSEL_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

  logic [IDX_W-1:0] idx;
  logic             unused_lsbs;
  dec_t             dec;
  logic [DW-1:0]    wdata_native;
  logic [DW-1:0]    rd_native;
  logic [DW-1:0]    rd_bus;

  logic [NUM_WIN-1:0][DW-1:0]  low_q, high_q, remap_q;
  logic [DW-1:0]               cpu_q, cfga_q;
  logic [NUM_CMD-1:0][DW-1:0]  cmd_q;
  logic [NUM_BANK-1:0][DW-1:0] bank_q;

  // named events for the checker
  logic             wr_low_hit;
  logic [SEL_W-1:0] wr_win_sel;

  assign idx         = bus_addr[11:2];
  assign unused_lsbs = ^bus_addr[1:0];

  hbr_byteswap #(.W(DW)) u_swap_wr (
    .en(big_endian_i), .din(bus_wdata), .dout(wdata_native)
  );

  hbr_decode #(.NUM_WIN(NUM_WIN), .NUM_BANK(NUM_BANK)) u_dec (
    .idx(idx), .dec(dec)
  );

  hbr_window_bank #(.NUM_WIN(NUM_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .kind(dec.kind), .sel(dec.sel),
    .wd(wdata_native), .low_q(low_q), .high_q(high_q), .remap_q(remap_q)
  );

  hbr_ctrl_regs #(.NUM_BANK(NUM_BANK), .NUM_CMD(NUM_CMD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .be_strap(big_endian_i), .wr_en(bus_we),
    .kind(dec.kind), .sel(dec.sel), .wd(wdata_native),
    .cpu_q(cpu_q), .cmd_q(cmd_q), .cfga_q(cfga_q), .bank_q(bank_q)
  );

  assign wr_low_hit  = bus_we && (dec.kind == K_WLOW);
  assign wr_win_sel  = dec.sel;
  assign cfg_wr_o    = bus_we && (dec.kind == K_CFGD);
  assign cfg_rd_o    = bus_re && (dec.kind == K_CFGD);
  assign cfg_wdata_o = wdata_native;
  assign cfg_addr_o  = cfga_q;

  always_comb begin
    case (dec.kind)
      K_CPU:    rd_native = cpu_q;
      K_WLOW:   rd_native = low_q[dec.sel];
      K_WHIGH:  rd_native = high_q[dec.sel];
      K_WREMAP: rd_native = remap_q[dec.sel];
      K_CMD:    rd_native = cmd_q[dec.sel[0]];
      K_CFGA:   rd_native = cfga_q;
      K_CFGD:   rd_native = cfg_rdata_i;
      K_BANK:   rd_native = bank_q[dec.sel[BSEL_W-1:0]];
      K_SYNC:   rd_native = SYNC_MARK;
      K_CONST:  rd_native = dec.konst;
      default:  rd_native = '0;
    endcase
  end

  hbr_byteswap #(.W(DW)) u_swap_rd (
    .en(big_endian_i), .din(rd_native), .dout(rd_bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_bus;
  end
endmodule

// File: rtl/hbr_regfile_chk.sv
module hbr_regfile_chk
  import hbr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       big_endian_i,
  input logic [11:0]                bus_addr,
  input logic                       bus_re,
  input logic [31:0]                bus_rdata,
  input logic                       cfg_rd_o,
  input logic [31:0]                cfg_rdata_i,
  input logic [31:0]                cfg_addr_o,
  input logic                       wr_low_hit,
  input logic [SEL_W-1:0]           wr_win_sel,
  input logic [DW-1:0]              wdata_native,
  input logic [NUM_WIN-1:0][DW-1:0] remap_q,
  input logic [NUM_WIN-1:0][DW-1:0] high_q
);
  // R11: read data holds when no read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R12: no configuration read request without a bus read
  a_r12_no_stray_cfg_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> !cfg_rd_o);

  // R12: reply word lands on the bus one edge later
  a_r12_cfg_reply: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_o |=> bus_rdata == (big_endian_i ? bswap32($past(cfg_rdata_i))
                                            : $past(cfg_rdata_i)));

  // R6: sync-barrier marker in little-endian mode
  a_r6_sync_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !big_endian_i &&
     (bus_addr[11:2] == IX_SYNC0 || bus_addr[11:2] == IX_SYNC1))
    |=> bus_rdata == SYNC_MARK);

  // R2: low-bound write is mirrored into the remap register
  a_r2_remap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low_hit |=> remap_q[$past(wr_win_sel)] == ($past(wdata_native) & MSK_REMAP));

  // R4: the latch never holds bits outside its mask
  a_r4_cfga_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_o & ~MSK_CFGA) == '0);

  // R3: high bounds never exceed seven bits
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hi
    a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      (high_q[w] & ~MSK_HIGH) == '0);
  end
endmodule

bind hbr_regfile hbr_regfile_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .bus_addr(bus_addr),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .cfg_rd_o(cfg_rd_o),
  .cfg_rdata_i(cfg_rdata_i), .cfg_addr_o(cfg_addr_o), .wr_low_hit(wr_low_hit),
  .wr_win_sel(wr_win_sel), .wdata_native(wdata_native), .remap_q(remap_q),
  .high_q(high_q)
);

// File: tb/test_hbr_regfile.sv
`timescale 1ns/1ps
module test_hbr_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] cfg_addr_o;
  logic        cfg_wr_o;
  logic        cfg_rd_o;
  logic [31:0] cfg_wdata_o;
  logic [31:0] cfg_rdata_i = 32'h1357_9BDF;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [0:1023];

  always #4 clk = ~clk;

  hbr_regfile i_hbr_regfile (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .cfg_addr_o(cfg_addr_o),
    .cfg_wr_o(cfg_wr_o), .cfg_rd_o(cfg_rd_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_rdata_i(cfg_rdata_i)
  );

  function automatic logic [31:0] rev(input logic [31:0] x);
    rev = '0;
    for (int b = 0; b < 4; b++) rev[8*b +: 8] = x[8*(3-b) +: 8];
  endfunction

  // window w: low at these indices, high = low+2, remap = 60+2w
  function automatic int low_of(input int w);
    int t[6] = '{18, 22, 32, 36, 40, 44};
    return t[w];
  endfunction

  function automatic int win_kind(input int i, output int w);
    w = 0;
    for (int k = 0; k < 6; k++) begin
      if (i == low_of(k))     begin w = k; return 1; end
      if (i == low_of(k) + 2) begin w = k; return 2; end
      if (i == 60 + 2*k)      begin w = k; return 3; end
    end
    return 0;
  endfunction

  function automatic string tag_of(input int i);
    int w;
    int k;
    k = win_kind(i, w);
    if (k == 1) return "R2";
    if (k != 0) return "R3";
    if (i == 'h300 || i == 'h320 || i == 'h33E) return "R4";
    if (i == 'h30 || i == 'h32) return "R6";
    if (i == 'h48 || i == 'h1C || i == 'h1E || i == 'h4A || i == 'h4C ||
        i == 'h4E || (i >= 'h120 && i <= 'h124)) return "R5";
    if (i >= 'h113 && i <= 'h116) return "R7";
    if (i == 0) return "R8";
    if (i == 'h33F) return "R12";
    return "R10";
  endfunction

  task automatic model_reset(input logic be);
    int lr[6] = '{'h080, 'h090, 'h790, 'h100, 'h110, 'h120};
    int hr[6] = '{'h00F, 'h01F, 'h01F, 'h00F, 'h01F, 'h02F};
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    for (int w = 0; w < 6; w++) begin
      mdl[low_of(w)]     = lr[w];
      mdl[low_of(w) + 2] = hr[w];
      mdl[60 + 2*w]      = lr[w];
    end
    mdl['h4A] = 32'hFFFF_FFFF;
    mdl['h4C] = 32'hFFFF_FFFF;
    mdl['h4E] = 32'h0000_00FF;
    for (int b = 0; b < 4; b++) mdl['h113 + b] = 32'd5;
    mdl[0]     = be ? 32'h0 : 32'h0000_1000;
    mdl['h300] = be ? 32'h0 : 32'h0001_0001;
    mdl['h320] = be ? 32'h0 : 32'h0001_0001;
  endtask

  task automatic model_write(input int i, input logic [31:0] n);
    int w;
    int k;
    k = win_kind(i, w);
    if (k == 1) begin
      mdl[i] = n % 32768;
      mdl[60 + 2*w] = n % 2048;
    end else if (k == 2) mdl[i] = n % 128;
    else if (k == 3)     mdl[i] = n % 2048;
    else if (i == 0 || (i >= 'h113 && i <= 'h116)) mdl[i] = n;
    else if (i == 'h300 || i == 'h320) mdl[i] = n & 32'h0401_FC0F;
    else if (i == 'h33E) mdl[i] = n & 32'h80FF_FFFC;
  endtask

  function automatic logic [31:0] model_read(input int i, input logic be);
    logic [31:0] v;
    if (i == 'h30 || i == 'h32) v = 32'hC000_FFEE;
    else if (i == 'h33F) v = cfg_rdata_i;
    else v = mdl[i];
    return be ? rev(v) : v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic be);
    @(negedge clk);
    rst_n = 1'b0;
    big_endian_i = be;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset(be);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sweep_read(input logic be, input string fixed);
    logic [31:0] d;
    for (int i = 0; i < 1024; i++) begin
      do_read(12'(i * 4), d);
      chk(fixed == "" ? tag_of(i) : fixed, d, model_read(i, be));
    end
  endtask

  task automatic sweep_write(input logic be, input logic [31:0] seed);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] v;
      v = (32'(i) * 32'h9E37_79B1) ^ seed;
      do_write(12'(i * 4), v);
      model_write(i, be ? rev(v) : v);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    // little-endian pass
    do_reset(1'b0);
    chk("R11 reset rdata", bus_rdata, 32'h0);
    sweep_read(1'b0, "R7");                 // R7 R8 R10 reset values
    sweep_write(1'b0, 32'hDEAD_BEEF);       // R2 R3 R4 R5 R10 writes
    sweep_read(1'b0, "");
    sweep_write(1'b0, 32'h5A5A_0F0F);
    sweep_read(1'b0, "");

    // R2: low write loads remap; R3: remap write leaves low alone
    do_write(12'h048, 32'hFFFF_FFFF); model_write('h12, 32'hFFFF_FFFF);
    do_read(12'h0F0, d); chk("R2 remap mirror", d, 32'h0000_07FF);
    do_write(12'h0F0, 32'h0000_0123); model_write(60, 32'h123);
    do_read(12'h048, d); chk("R3 low untouched", d, 32'h0000_7FFF);

    // R1: byte offset bits do not change the register
    do_write(12'h44F, 32'hCAFE_F00D);
    do_read(12'h44D, d); chk("R1 byte offset", d, 32'hCAFE_F00D);

    // R11: value held without read strobe
    held = bus_rdata;
    repeat (3) @(negedge clk);
    chk("R11 hold", bus_rdata, held);

    // R4: latch mask visible on cfg_addr_o
    do_write(12'hCF8, 32'hFFFF_FFFF);
    chk("R4 cfg addr", cfg_addr_o, 32'h80FF_FFFC);

    // R12: config data pass-through
    @(negedge clk);
    bus_addr = 12'hCFC; bus_wdata = 32'h1122_3344; bus_we = 1'b1;
    #2;
    chk("R12 cfg_wr_o", {31'b0, cfg_wr_o}, 32'h1);
    chk("R12 cfg_wdata_o", cfg_wdata_o, 32'h1122_3344);
    @(negedge clk);
    bus_we = 1'b0;
    cfg_rdata_i = 32'hA1B2_C3D4;
    @(negedge clk);
    bus_addr = 12'hCFC; bus_re = 1'b1;
    #2;
    chk("R12 cfg_rd_o", {31'b0, cfg_rd_o}, 32'h1);
    @(negedge clk);
    bus_re = 1'b0;
    chk("R12 reply", bus_rdata, 32'hA1B2_C3D4);

    // R6 marker, R5 multi reads zero after write
    do_read(12'h0C8, d); chk("R6 sync", d, 32'hC000_FFEE);
    do_write(12'h120, 32'h1234_5678);
    do_read(12'h120, d); chk("R5 multi", d, 32'h0);

    // big-endian pass: R8 reset values, R9 byte reversal
    do_reset(1'b1);
    sweep_read(1'b1, "R8");
    sweep_write(1'b1, 32'h0BAD_CAFE);
    sweep_read(1'b1, "R9");
    do_write(12'h44C, 32'h0102_0304);
    do_read(12'h44C, d); chk("R9 round trip", d, 32'h0102_0304);
    do_write(12'h000, 32'h0000_0080);
    big_endian_i = 1'b1;
    do_read(12'h0C0, d); chk("R9 sync reversed", d, 32'hEEFF_00C0);
    @(negedge clk);
    bus_addr = 12'hCFC; bus_wdata = 32'h1122_3344; bus_we = 1'b1;
    #2;
    chk("R9 cfg wdata reversed", cfg_wdata_o, 32'h4433_2211);
    @(negedge clk);
    bus_we = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule